// File: doc/BRIEF.md
# Dual-Lane Control Symbol FIFO Decoder

This block sits behind a 64-bit receive datapath. In any one clock, that datapath can carry zero, one or two 32-bit control symbols. Each half of the word has its own present flag. Each symbol is an 8-bit special character followed by 24 bits of content.

Every clock that brings at least one symbol writes exactly one queue entry. That entry holds both halves and one valid bit for each half. A drain stage reads entries back in order and emits one decoded symbol per clock. Each decoded symbol carries a one-hot type vector, an acknowledge identifier, the remaining information bits and a flag for a wrong special character. An entry leaves the queue only after every valid half in it has been emitted. When a symbol word arrives while the queue is full, the word is dropped and a sticky overflow flag is raised.

Downstream acknowledge tracking and retry logic consume the output records. The output has no back-pressure: records appear as soon as they are decoded.

Top module: `csym_fifo_decoder`

## Requirements
- R1: In the input word, bits [63:32] hold the earlier symbol and bits [31:0] the later one. Within a 32-bit symbol, bits [31:24] are the special character and bits [23:21] the 3-bit type. The acknowledge identifier is the ACKID_W bits starting at bit 20 and running downward. Bits [14:0] are the information field.
- R2: A clock edge with at least one of `in_hi_vld` or `in_lo_vld` high stores one queue entry. An edge with both flags low stores nothing and later produces no output record.
- R3: Output records keep arrival order. The upper symbol of an entry comes before its lower symbol, an absent half is skipped, and at most one record is emitted per clock.
- R4: When `out_vld` is high, `out_kind` has exactly bit t set, where t is the symbol's type field. Bit 0 means packet accepted, bit 1 packet retry and bit 2 packet not accepted; bits 3 to 7 are the remaining types.
- R5: `out_ackid` and `out_info` equal the acknowledge identifier and information fields of the emitted symbol, as laid out in R1.
- R6: `out_sc_err` is high with a record exactly when that symbol's special character differs from parameter SC_CODE (default 8'h7C). It is never high without `out_vld`.
- R7: Take a word written at clock edge E while the queue is empty. Its first symbol appears on the outputs after edge E+1. Its second symbol, if present, appears after edge E+2.
- R8: A symbol word presented while the queue holds DEPTH entries is dropped, even if an entry leaves at the same edge. The drop sets `overflow`, which then stays high until reset.
- R9: After reset, `out_vld` and `overflow` are low and the queue is empty.
- R10: When `out_vld` is low, `out_kind` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 64 | Received datapath word holding two symbol slots |
| in_hi_vld | input | 1 | A symbol is present in bits [63:32] |
| in_lo_vld | input | 1 | A symbol is present in bits [31:0] |
| out_vld | output | 1 | A decoded record is on the outputs this cycle |
| out_kind | output | 8 | One-hot symbol type |
| out_ackid | output | ACKID_W | Acknowledge identifier of the symbol |
| out_info | output | 15 | Remaining information bits of the symbol |
| out_sc_err | output | 1 | Special character did not match SC_CODE |
| overflow | output | 1 | Sticky flag: a symbol word was dropped on a full queue |

## Verification
The bench builds the block with DEPTH set to 4 and ACKID_W set to 5. The shallow queue lets a short burst of double-symbol words outrun the one-per-clock drain, so the drop path and the sticky flag are reached within a few clocks. The narrower identifier shows that the field is taken from the top of the content bits and that bit 15 is ignored. With the default SC_CODE, deliberately corrupted special characters exercise the error flag next to well-formed symbols of all eight types.

// File: rtl/csym_pkg.sv
package csym_pkg;

    localparam int WORD_W    = 64;
    localparam int SYM_W     = 32;
    localparam int SC_W      = 8;
    localparam int TYPE_W    = 3;
    localparam int BODY_W    = SYM_W - SC_W - TYPE_W;   // 21 content bits below the type
    localparam int INFO_W    = 15;
    localparam int NUM_KINDS = 1 << TYPE_W;

    typedef struct packed {
        logic [SC_W-1:0]   sc;
        logic [TYPE_W-1:0] kind;
        logic [BODY_W-1:0] body;
    } sym_t;

    typedef struct packed {
        logic hv;   // upper (earlier) half present
        logic lv;   // lower (later) half present
        sym_t hi;
        sym_t lo;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    function automatic logic [NUM_KINDS-1:0] kind_onehot(input logic [TYPE_W-1:0] k);
        logic [NUM_KINDS-1:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    function automatic entry_t pack_entry(input logic [WORD_W-1:0] w,
                                          input logic hv, input logic lv);
        entry_t e;
        e.hv = hv;
        e.lv = lv;
        e.hi = sym_t'(w[WORD_W-1:SYM_W]);
        e.lo = sym_t'(w[SYM_W-1:0]);
        return e;
    endfunction

endpackage

// File: rtl/csym_capture.sv
module csym_capture
    import csym_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_hi_vld,
    input  logic              in_lo_vld,
    input  logic              q_full,
    output logic              wr_en,
    output entry_t            wr_entry,
    output logic              overflow
);

    logic wr_req;

    always_comb begin
        wr_req   = in_hi_vld | in_lo_vld;
        wr_en    = wr_req & ~q_full;
        wr_entry = pack_entry(in_word, in_hi_vld, in_lo_vld);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow <= 1'b0;
        end else if (wr_req && q_full) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/csym_fifo.sv
module csym_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        full    = (cnt == CW'(DEPTH));
        empty   = (cnt == '0);
        do_wr   = wr_en & ~full;
        do_rd   = rd_en & ~empty;
        rd_data = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= bump(wp);
            if (do_rd) rp <= bump(rp);
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/csym_drain.sv
module csym_drain
    import csym_pkg::*;
#(
    parameter int              ACKID_W = 6,
    parameter logic [SC_W-1:0] SC_CODE = 8'h7C
) (
    input  logic                 clk,
    input  logic                 rst,
    input  entry_t               head,
    input  logic                 q_empty,
    output logic                 pop,
    output logic                 out_vld,
    output logic [NUM_KINDS-1:0] out_kind,
    output logic [ACKID_W-1:0]   out_ackid,
    output logic [INFO_W-1:0]    out_info,
    output logic                 out_sc_err
);

    logic second;     // upper half of the head entry already emitted
    logic take_lo;
    logic last;
    sym_t pick;

    always_comb begin
        take_lo = second | ~head.hv;
        pick    = take_lo ? head.lo : head.hi;
        last    = take_lo | ~head.lv;
        pop     = ~q_empty & last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            second     <= 1'b0;
            out_vld    <= 1'b0;
            out_kind   <= '0;
            out_ackid  <= '0;
            out_info   <= '0;
            out_sc_err <= 1'b0;
        end else if (!q_empty) begin
            second     <= ~last;
            out_vld    <= 1'b1;
            out_kind   <= kind_onehot(pick.kind);
            out_ackid  <= pick.body[BODY_W-1 -: ACKID_W];
            out_info   <= pick.body[INFO_W-1:0];
            out_sc_err <= (pick.sc != SC_CODE);
        end else begin
            out_vld    <= 1'b0;
            out_kind   <= '0;
            out_sc_err <= 1'b0;
        end
    end

endmodule

// File: rtl/csym_fifo_decoder.sv
module csym_fifo_decoder
    import csym_pkg::*;
#(
    parameter int              DEPTH   = 4,
    parameter int              ACKID_W = 6,
    parameter logic [SC_W-1:0] SC_CODE = 8'h7C
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WORD_W-1:0]    in_word,
    input  logic                 in_hi_vld,
    input  logic                 in_lo_vld,
    output logic                 out_vld,
    output logic [NUM_KINDS-1:0] out_kind,
    output logic [ACKID_W-1:0]   out_ackid,
    output logic [INFO_W-1:0]    out_info,
    output logic                 out_sc_err,
    output logic                 overflow
);

    logic               wr_en, pop, q_full, q_empty;
    entry_t             wr_entry, head;
    logic [ENTRY_W-1:0] head_raw;

    csym_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .in_word   (in_word),
        .in_hi_vld (in_hi_vld),
        .in_lo_vld (in_lo_vld),
        .q_full    (q_full),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .overflow  (overflow)
    );

    csym_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_entry),
        .rd_en   (pop),
        .rd_data (head_raw),
        .full    (q_full),
        .empty   (q_empty)
    );

    assign head = entry_t'(head_raw);

    csym_drain #(.ACKID_W(ACKID_W), .SC_CODE(SC_CODE)) u_drain (
        .clk        (clk),
        .rst        (rst),
        .head       (head),
        .q_empty    (q_empty),
        .pop        (pop),
        .out_vld    (out_vld),
        .out_kind   (out_kind),
        .out_ackid  (out_ackid),
        .out_info   (out_info),
        .out_sc_err (out_sc_err)
    );

endmodule

// File: rtl/csym_fifo_decoder_chk.sv
module csym_fifo_decoder_chk
    import csym_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_hi_vld,
    input logic                 in_lo_vld,
    input logic                 out_vld,
    input logic [NUM_KINDS-1:0] out_kind,
    input logic                 out_sc_err,
    input logic                 overflow
);

    // R4
    kind_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($countones(out_kind) == 1));

    // R10
    idle_kind_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (out_kind == '0));

    // R6
    sc_err_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        out_sc_err |-> out_vld);

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R8
    overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(in_hi_vld || in_lo_vld));

endmodule

bind csym_fifo_decoder csym_fifo_decoder_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_hi_vld  (in_hi_vld),
    .in_lo_vld  (in_lo_vld),
    .out_vld    (out_vld),
    .out_kind   (out_kind),
    .out_sc_err (out_sc_err),
    .overflow   (overflow)
);

// File: tb/csym_fifo_decoder_tb_top.sv
module csym_fifo_decoder_tb_top;

    localparam int DEPTH   = 4;
    localparam int ACKID_W = 5;

    typedef struct packed {
        logic [7:0]         kind;
        logic [ACKID_W-1:0] ackid;
        logic [14:0]        info;
        logic               scerr;
    } rec_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [63:0]        in_word = '0;
    logic               in_hi_vld = 1'b0;
    logic               in_lo_vld = 1'b0;
    logic               out_vld;
    logic [7:0]         out_kind;
    logic [ACKID_W-1:0] out_ackid;
    logic [14:0]        out_info;
    logic               out_sc_err;
    logic               overflow;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   mon_en = 1'b0;
    int   ignored = 0;
    rec_t exp_q[$];
    logic [31:0] lfsr = 32'hACE1_2B47;

    always #5 clk = ~clk;

    csym_fifo_decoder #(.DEPTH(DEPTH), .ACKID_W(ACKID_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_word    (in_word),
        .in_hi_vld  (in_hi_vld),
        .in_lo_vld  (in_lo_vld),
        .out_vld    (out_vld),
        .out_kind   (out_kind),
        .out_ackid  (out_ackid),
        .out_info   (out_info),
        .out_sc_err (out_sc_err),
        .overflow   (overflow)
    );

    // R1 R4 R5 R6: expected record of one 32-bit symbol
    function automatic rec_t model(input logic [31:0] s);
        rec_t r;
        r.kind  = 8'(1) << s[23:21];
        r.ackid = s[20 -: ACKID_W];
        r.info  = s[14:0];
        r.scerr = (s[31:24] != 8'h7C);
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // driver: one clock of input, expected items queued hi first (R1 R3)
    task automatic send(input bit hv, input bit lv, input logic [63:0] w);
        @(negedge clk);
        in_word   = w;
        in_hi_vld = hv;
        in_lo_vld = lv;
        if (mon_en) begin
            if (hv) exp_q.push_back(model(w[63:32]));
            if (lv) exp_q.push_back(model(w[31:0]));
        end
        @(negedge clk);
        in_hi_vld = 1'b0;
        in_lo_vld = 1'b0;
        in_word   = 64'hDEAD_BEEF_DEAD_BEEF;   // R2: word without flags must be ignored
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input logic [7:0] sc, input logic [2:0] t);
        logic [31:0] r;
        r = next_rand();
        return {sc, t, r[20:0]};
    endfunction

    // monitor / scoreboard (R3 R4 R5 R6)
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (!mon_en) begin
                ignored++;
            end else if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R2: actual unexpected record kind %h, expected none", out_kind);
            end else begin
                rec_t e;
                e = exp_q.pop_front();
                check("R4 kind", 64'(out_kind), 64'(e.kind));
                check("R5 ackid", 64'(out_ackid), 64'(e.ackid));
                check("R5 info", 64'(out_info), 64'(e.info));
                check("R6 sc_err", 64'(out_sc_err), 64'(e.scerr));
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 out_vld", 64'(out_vld), 64'd0);
        check("R9 overflow", 64'(overflow), 64'd0);
        check("R10 kind idle", 64'(out_kind), 64'd0);
        mon_en = 1'b1;

        // R7 latency from empty with a double word
        @(negedge clk);
        in_word   = {mk(8'h7C, 3'd0), mk(8'h7C, 3'd1)};
        in_hi_vld = 1'b1;
        in_lo_vld = 1'b1;
        exp_q.push_back(model(in_word[63:32]));
        exp_q.push_back(model(in_word[31:0]));
        @(negedge clk);
        in_hi_vld = 1'b0;
        in_lo_vld = 1'b0;
        check("R7 not yet after write edge", 64'(out_vld), 64'd0);
        @(negedge clk);
        check("R7 first after E+1", 64'(out_vld), 64'd1);
        check("R3 upper first", 64'(out_kind), 64'h01);
        @(negedge clk);
        check("R7 second after E+2", 64'(out_vld), 64'd1);
        check("R3 lower second", 64'(out_kind), 64'h02);
        idle(3);

        // every type, single halves and doubles, some bad special characters
        for (int t = 0; t < 8; t++) begin
            send(1'b1, 1'b0, {mk(8'h7C, 3'(t)), 32'h0});
            send(1'b0, 1'b1, {32'hFFFF_FFFF, mk((t % 3 == 0) ? 8'hBC : 8'h7C, 3'(7 - t))});
            send(1'b1, 1'b1, {mk(8'h7C, 3'(t)), mk(8'h7C, 3'((t + 2) % 8))});
            idle(1);
        end
        // pseudo-random flags and contents, kept below the drain rate
        for (int i = 0; i < 40; i++) begin
            logic [31:0] r;
            r = next_rand();
            send(r[0], r[1], {mk(r[2] ? 8'h7C : 8'h1C, r[5:3]), mk(8'h7C, r[8:6])});
            if (r[0] && r[1]) idle(1);
        end
        idle(8);
        check("R2 R3 all expected records seen", 64'(exp_q.size()), 64'd0);
        check("R8 no overflow below capacity", 64'(overflow), 64'd0);

        // R8 overflow: back-to-back double words outrun the drain
        mon_en = 1'b0;
        ignored = 0;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            in_word   = {mk(8'h7C, 3'd2), mk(8'h7C, 3'd0)};
            in_hi_vld = 1'b1;
            in_lo_vld = 1'b1;
            @(negedge clk);
        end
        in_hi_vld = 1'b0;
        in_lo_vld = 1'b0;
        check("R8 overflow set", 64'(overflow), 64'd1);
        idle(30);
        check("R8 overflow sticky", 64'(overflow), 64'd1);
        check("R8 words dropped", 64'(ignored < 20), 64'd1);
        check("R3 whole entries drained", 64'(ignored % 2), 64'd0);

        // R9 reset clears the flag and the queue
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check("R9 overflow cleared", 64'(overflow), 64'd0);
        check("R9 out_vld cleared", 64'(out_vld), 64'd0);
        idle(3);
        check("R9 queue empty", 64'(out_vld), 64'd0);
        mon_en = 1'b1;
        send(1'b1, 1'b1, {mk(8'h7C, 3'd5), mk(8'h00, 3'd6)});
        idle(5);
        check("R3 post-reset records seen", 64'(exp_q.size()), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule